// File: doc/BRIEF.md
# ADC Result Gain and Offset Corrector

This block is a purely digital stage that sits behind an analog-to-digital converter and repairs its result after each conversion has finished. Every raw sample that arrives with a valid strobe has a signed offset removed. It is then scaled by an unsigned fixed-point gain, rounded, and clipped to the selected result width. The block has no part in any analog offset compensation inside the converter.

Software sets the block up through a small write-only register port that holds three words. The control word carries the correction enable and the result width. The gain word is in UQ1.11 format, so 0x800 means 1.0 and 0x400 means 0.5. The offset word is a two's-complement number. When the enable is clear, each sample is passed through unchanged, with the same latency as a corrected sample. Each sample takes a snapshot of the configuration in the cycle it is accepted and carries that snapshot down the two-stage pipeline with it. A register write therefore never changes a sample that is already in flight.

Top module: `adc_corr_top`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` is low and `out_data` is zero. Reset loads enable=0, width code 00, gain 0x800 and offset 0.
- R2: A sample accepted with `in_valid` high in cycle t appears with `out_valid` high in cycle t+2. A cycle with `in_valid` low gives `out_valid` low two cycles later.
- R3: When control bit 0 (enable) is 0, `out_data` equals the raw `in_data` exactly, and neither gain nor offset has any effect.
- R4: When enabled, `out_data` = floor(((raw − offset) × gain + 1024) / 2048), clipped as in R6 and R7. The gain is written at address 1, bits 11:0, in UQ1.11. The offset is written at address 2, bits 11:0, as a 12-bit two's-complement value. The control word is at address 0.
- R5: A gain write below 0x400 is stored as 0x400, so any gain under 0.5 behaves exactly as a gain of 0.5.
- R6: A corrected value below zero is output as 0.
- R7: A corrected value above 2^N−1 is output as 2^N−1. N is set by control bits 2:1: code 00 gives 12, 01 gives 10, 10 gives 8 and 11 gives 12.
- R8: A sample uses the configuration held in the cycle it is accepted. A write in that same cycle, or in any later cycle, takes effect only from the next sample accepted.
- R9: When the discarded fraction of the scaled value is exactly one half, the result rounds upward (for example, raw 3 with gain 0x400 gives 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word select: 0 control, 1 gain, 2 offset |
| cfg_wdata | input | 12 | Configuration write data |
| in_valid | input | 1 | Raw sample valid |
| in_data | input | 12 | Raw converter result |
| out_valid | output | 1 | Corrected sample valid |
| out_data | output | 12 | Corrected or passed-through result |

## Verification
The bench sweeps raw codes over gain settings at both ends of their range (0.5 and the all-ones value), at 1.0 and at an odd value. It also sweeps offsets at both signed extremes and all three result widths. It predicts each output by integer arithmetic. Rounding that truncated would show up at exact halves. An offset added instead of subtracted, or an offset not sign-extended, would move whole sweeps. A limit tied to the wrong width code would show up once the result saturates. Gains below the floor are written and then observed at the output, which catches a missing clamp. Writes are placed in the same cycle as an accept and while a sample sits in the first stage. A design that read the live gain in its second stage would scale that sample with the new value.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  typedef enum logic [1:0] {
    RES_FULL  = 2'b00,
    RES_TEN   = 2'b01,
    RES_EIGHT = 2'b10,
    RES_FULLB = 2'b11
  } res_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_GAIN = 2'd1;
  localparam logic [1:0] ADDR_OFS  = 2'd2;
endpackage

// File: rtl/adc_corr_cfg.sv
module adc_corr_cfg
  import adc_corr_pkg::*;
#(
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 11,
  parameter int OFS_W     = 12,
  parameter int CFG_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [1:0]              addr,
  input  logic [CFG_W-1:0]        wdata,
  output logic                    en_o,
  output res_e                    res_o,
  output logic [GAIN_W-1:0]       gain_o,
  output logic signed [OFS_W-1:0] ofs_o
);
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;
  localparam logic [GAIN_W-1:0] GAIN_MIN = GAIN_W'(1) << (GAIN_FRAC - 1);

  logic                    en_q, en_d;
  res_e                    res_q, res_d;
  logic [GAIN_W-1:0]       gain_q, gain_d, gain_w;
  logic signed [OFS_W-1:0] ofs_q, ofs_d;

  always_comb begin
    en_d   = en_q;
    res_d  = res_q;
    gain_d = gain_q;
    ofs_d  = ofs_q;
    gain_w = wdata[GAIN_W-1:0];
    if (we) begin
      unique case (addr)
        ADDR_CTRL: begin
          en_d  = wdata[0];
          res_d = res_e'(wdata[2:1]);
        end
        ADDR_GAIN: gain_d = (gain_w < GAIN_MIN) ? GAIN_MIN : gain_w;
        ADDR_OFS:  ofs_d  = $signed(wdata[OFS_W-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      res_q  <= RES_FULL;
      gain_q <= GAIN_ONE;
      ofs_q  <= '0;
    end else if (we) begin
      en_q   <= en_d;
      res_q  <= res_d;
      gain_q <= gain_d;
      ofs_q  <= ofs_d;
    end
  end

  assign en_o   = en_q;
  assign res_o  = res_q;
  assign gain_o = gain_q;
  assign ofs_o  = ofs_q;

  // R5: the stored gain never drops below one half
  a_r5_gain_floor: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q >= GAIN_MIN);
endmodule

// File: rtl/adc_corr_sub.sv
module adc_corr_sub
  import adc_corr_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int OFS_W  = 12,
  parameter int GAIN_W = 12,
  parameter int DIFF_W = RAW_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [RAW_W-1:0]         in_data,
  input  logic                     en,
  input  res_e                     res,
  input  logic [GAIN_W-1:0]        gain,
  input  logic signed [OFS_W-1:0]  ofs,
  output logic                     s1_valid,
  output logic signed [DIFF_W-1:0] s1_diff,
  output logic                     s1_en,
  output res_e                     s1_res,
  output logic [GAIN_W-1:0]        s1_gain
);
  logic [DIFF_W-1:0] raw_ext, ofs_ext, diff_d;

  always_comb begin
    raw_ext = {{(DIFF_W-RAW_W){1'b0}}, in_data};
    ofs_ext = {{(DIFF_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    diff_d  = en ? (raw_ext - ofs_ext) : raw_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_diff <= '0;
      s1_en   <= 1'b0;
      s1_res  <= RES_FULL;
      s1_gain <= '0;
    end else if (in_valid) begin
      s1_diff <= $signed(diff_d);
      s1_en   <= en;
      s1_res  <= res;
      s1_gain <= gain;
    end
  end

  // R2: an accepted sample occupies the first stage on the next cycle
  a_r2_stage1_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
endmodule

// File: rtl/adc_corr_mul.sv
module adc_corr_mul
  import adc_corr_pkg::*;
#(
  parameter int DIFF_W    = 14,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 11,
  parameter int OUT_W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic signed [DIFF_W-1:0] s1_diff,
  input  logic                     s1_en,
  input  res_e                     s1_res,
  input  logic [GAIN_W-1:0]        s1_gain,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_data
);
  localparam int PROD_W = DIFF_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (GAIN_FRAC - 1);

  function automatic logic [OUT_W-1:0] lim_of(input res_e r);
    case (r)
      RES_TEN:   lim_of = {OUT_W{1'b1}} >> (OUT_W - 10);
      RES_EIGHT: lim_of = {OUT_W{1'b1}} >> (OUT_W - 8);
      default:   lim_of = {OUT_W{1'b1}};
    endcase
  endfunction

  logic signed [PROD_W-1:0] prod, scaled, lim_ext;
  logic [OUT_W-1:0]         lim, data_d;

  always_comb begin
    prod    = $signed(s1_diff) * $signed({1'b0, s1_gain});
    scaled  = (prod + HALF) >>> GAIN_FRAC;
    lim     = lim_of(s1_res);
    lim_ext = $signed({{(PROD_W-OUT_W){1'b0}}, lim});
    if (!s1_en)                data_d = s1_diff[OUT_W-1:0];
    else if (scaled < 0)       data_d = '0;
    else if (scaled > lim_ext) data_d = lim;
    else                       data_d = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_data <= '0;
    else if (s1_valid) out_data <= data_d;
  end

  // R2: the first stage always drains into the output stage
  a_r2_stage2_fill: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  // R7: a corrected output never exceeds the width limit it was issued with
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_en) |=> (out_data <= lim_of($past(s1_res))));
endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top
  import adc_corr_pkg::*;
#(
  parameter int RAW_W     = 12,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 11,
  parameter int OFS_W     = 12,
  parameter int CFG_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_valid,
  input  logic [RAW_W-1:0] in_data,
  output logic             out_valid,
  output logic [RAW_W-1:0] out_data
);
  localparam int DIFF_W = RAW_W + 2;

  logic                     en_q;
  res_e                     res_q;
  logic [GAIN_W-1:0]        gain_q;
  logic signed [OFS_W-1:0]  ofs_q;
  logic                     s1_valid, s1_en;
  logic signed [DIFF_W-1:0] s1_diff;
  res_e                     s1_res;
  logic [GAIN_W-1:0]        s1_gain;

  adc_corr_cfg #(.GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OFS_W(OFS_W), .CFG_W(CFG_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_o(en_q), .res_o(res_q), .gain_o(gain_q), .ofs_o(ofs_q)
  );

  adc_corr_sub #(.RAW_W(RAW_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W), .DIFF_W(DIFF_W)) i_sub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .en(en_q), .res(res_q), .gain(gain_q), .ofs(ofs_q),
    .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_en(s1_en), .s1_res(s1_res), .s1_gain(s1_gain)
  );

  adc_corr_mul #(.DIFF_W(DIFF_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(RAW_W)) i_mul (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_en(s1_en),
    .s1_res(s1_res), .s1_gain(s1_gain), .out_valid(out_valid), .out_data(out_data)
  );

  // R2: output valid follows input valid by exactly two cycles
  a_r2_latency_hi: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  a_r2_latency_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  // R3: with correction off the raw code comes out untouched
  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en_q) |-> ##2 (out_data == $past(in_data, 2)));
endmodule

// File: tb/test_adc_corr_top.sv
module test_adc_corr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        in_valid;
  logic [11:0] in_data;
  logic        out_valid;
  logic [11:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int m_en, m_res, m_gain, m_ofs;
  bit e0_v, e1_v;
  int e0_d, e1_d;
  string e0_t, e1_t;

  always #2.5 clk = ~clk;

  adc_corr_top i_adc_corr_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int lim_of(int r);
    if (r == 1) return 1023;
    if (r == 2) return 255;
    return 4095;
  endfunction

  function automatic int expv(int raw, output string tag);
    int p, q;
    if (m_en == 0) begin tag = "R3"; return raw; end
    p = (raw - m_ofs) * m_gain;
    q = (p + 1024) >>> 11;
    if (q < 0) begin tag = "R6"; return 0; end
    if (q > lim_of(m_res)) begin tag = "R7"; return lim_of(m_res); end
    tag = ((p & 2047) == 1024) ? "R9" : "R4";
    return q;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== e1_v || (e1_v && out_data !== e1_d[11:0])) begin
      errors++;
      $display("FAIL %s valid=%0b data=%0d expected valid=%0b data=%0d",
               e1_t, out_valid, out_data, e1_v, e1_d);
    end
  endtask

  task automatic step(input bit v, input int raw, input bit we, input int addr,
                      input int wd, input string ovr);
    string t;
    int g;
    @(negedge clk);
    compare();
    e1_v = e0_v; e1_d = e0_d; e1_t = e0_t;
    e0_v = v;
    if (v) e0_d = expv(raw, t); else begin e0_d = 0; t = "R2"; end
    e0_t = (ovr != "") ? ovr : t;
    if (we) begin
      if (addr == 0) begin m_en = wd & 1; m_res = (wd >> 1) & 3; end
      if (addr == 1) begin g = wd & 4095; m_gain = (g < 1024) ? 1024 : g; end
      if (addr == 2) m_ofs = ((wd & 2048) != 0) ? (wd & 4095) - 4096 : (wd & 4095);
    end
    in_valid  = v;
    in_data   = raw[11:0];
    cfg_we    = we;
    cfg_addr  = addr[1:0];
    cfg_wdata = wd[11:0];
  endtask

  task automatic wr(input int addr, input int wd);
    step(1'b0, 0, 1'b1, addr, wd, "");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int gains[4];
    int offs[5];
    gains = '{1024, 2048, 4095, 1443};
    offs  = '{0, -2048, 2047, -1, 37};
    m_en = 0; m_res = 0; m_gain = 2048; m_ofs = 0;
    e0_v = 0; e1_v = 0; e0_d = 0; e1_d = 0; e0_t = "R2"; e1_t = "R2";
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; in_valid = 0; in_data = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 12'd0) begin
      errors++;
      $display("FAIL R1 valid=%0b data=%0d expected valid=0 data=0", out_valid, out_data);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R3: passthrough sweep with gain and offset far from neutral
    wr(1, 1024); wr(2, 700);
    for (int r = 0; r < 4096; r++) step(1'b1, r, 1'b0, 0, 0, "R3");

    // R4: identity sweep at gain 1.0, offset 0
    wr(1, 2048); wr(2, 0); wr(0, 1);
    for (int r = 0; r < 4096; r++) step(1'b1, r, 1'b0, 0, 0, "");

    // R4 R6 R7 R9: gain x offset x width sweeps, with idle gaps (R2)
    for (int gi = 0; gi < 4; gi++)
      for (int oi = 0; oi < 5; oi++)
        for (int rs = 0; rs < 3; rs++) begin
          wr(1, gains[gi]); wr(2, offs[oi] & 4095); wr(0, 1 | (rs << 1));
          for (int r = 0; r < 4096; r += 13) step((r % 91) != 0, r, 1'b0, 0, 0, "");
          step(1'b1, 4095, 1'b0, 0, 0, "");
        end

    // R9: exact half rounds up at gain 0.5
    wr(1, 1024); wr(2, 0); wr(0, 1);
    step(1'b1, 3, 1'b0, 0, 0, "R9");
    step(1'b1, 1, 1'b0, 0, 0, "R9");

    // R5: gains below 0.5 behave as 0.5
    wr(2, 0); wr(0, 1);
    for (int gw = 0; gw < 1024; gw += 73) begin
      wr(1, gw);
      step(1'b1, 4001, 1'b0, 0, 0, "R5");
      step(1'b1, 77, 1'b0, 0, 0, "R5");
    end
    wr(1, 1023);
    for (int r = 0; r < 4096; r += 5) step(1'b1, r, 1'b0, 0, 0, "R5");

    // R8: writes coinciding with accept or landing while a sample is in flight
    wr(1, 2048); wr(2, 0); wr(0, 1);
    step(1'b1, 1000, 1'b1, 1, 3072, "R8");
    step(1'b1, 1000, 1'b0, 0, 0, "R8");
    step(1'b1, 2000, 1'b0, 0, 0, "R8");
    step(1'b0, 0, 1'b1, 2, 500, "");
    step(1'b1, 2000, 1'b1, 0, 0, "R8");
    step(1'b1, 2000, 1'b1, 0, 3, "R8");
    step(1'b1, 2000, 1'b1, 0, 5, "R8");
    step(1'b1, 2000, 1'b0, 0, 0, "R8");
    for (int k = 0; k < 40; k++)
      step(1'b1, (k * 397) % 4096, 1'b1, (k % 3), (k * 911) % 4096, "R8");

    repeat (3) step(1'b0, 0, 1'b0, 0, 0, "");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule